// File: doc/BRIEF.md
# Two-Wire Addressed Command Slave

This block is a slave on an open-drain two-wire serial bus that turns bus writes into single-cycle command strobes for a neighbouring PWM register block and answers reads with that block's status. Raw SCL and SDA enter through synchronizers and a stability filter. Start and stop conditions and SCL edges are then extracted from the filtered lines. A byte-level state machine decodes them.

A transfer begins with a control byte. It is accepted only when it carries the fixed device code and the address set by three strap pins. After a write control byte, every data byte is acknowledged. Its upper three bits pick an operation and its lower five bits carry a duty value. After a read control byte, the slave shifts out a status byte for as long as the master acknowledges. Stop and repeated-start conditions abort whatever is in flight.

Top module: `twi_cmd_slave`

## Requirements
- R1: After reset `sda_pull` is 0 and no strobe is active. A start (SDA falling while SCL is high) begins control-byte decoding. A stop (SDA rising while SCL is high) returns the block to idle with `sda_pull` at 0.
- R2: The control byte is received MSB first as bits [7:4] device code (default 4'b0101), bits [3:1] address, and bit [0] direction (1 = read, 0 = write). When the code matches and the address equals `addr_strap` (bit 3 compared with strap bit 2), the slave pulls SDA low through the ninth clock.
- R3: A control byte with a wrong code or wrong address is not acknowledged. Every byte after it, up to the next start, is neither acknowledged nor acted on.
- R4: In a write, each 8-bit data byte is acknowledged. Bits [7:5] form the operation field and bits [4:0] the duty value.
- R5: Operation field 000 pulses `duty_we` with `duty_val` equal to bits [4:0]. Field 001 pulses `fullon_stb`, 110 pulses `shutdown_stb`, and 100 pulses `recall_stb`. Any other field pulses nothing. Each strobe lasts one cycle, no two are active together, and a strobe fires only when the acknowledge clock of its byte begins.
- R6: A write may carry any number of data bytes, and each is applied in order.
- R7: A read returns, MSB first, the byte {`cur_shutdown`, 2'b00, `cur_duty`}. The slave changes SDA only while SCL is low.
- R8: The slave keeps sending status bytes while the master acknowledges (SDA low on the ninth clock). After a not-acknowledge it leaves SDA released.
- R9: A repeated start in the middle of a byte discards that byte without any strobe and restarts control-byte decoding.
- R10: A stop in the middle of a byte discards it without any strobe.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles has no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| addr_strap | input | 3 | Pin-strapped slave address |
| cur_duty | input | 5 | Current duty value from the register block |
| cur_shutdown | input | 1 | Current shutdown flag from the register block |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| duty_we | output | 1 | Strobe: load `duty_val` as the duty value |
| duty_val | output | 5 | Duty value carried with `duty_we` |
| fullon_stb | output | 1 | Strobe: force full-on output |
| shutdown_stb | output | 1 | Strobe: enter shutdown |
| recall_stb | output | 1 | Strobe: leave shutdown |

## Verification
The bench builds the block with `FILT_LEN` = 4, the default device code, and the straps tied to 3'b101. It uses ten system clocks per quarter bit, which leaves room for the filter and synchronizer delay before every SCL edge. With a filter length of 4, a three-cycle glitch on either line is just short enough to be rejected, so the same bench exercises both rejection and normal decoding. A single wrong code bit or a single wrong strap bit is enough to exercise address refusal.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

  localparam int DUTY_W = 5;
  localparam int OP_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_DACK, ST_TX, ST_MACK
  } twi_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_DUTY, OP_FULL, OP_SHUT, OP_RECALL
  } twi_op_e;

  // control byte: [7:4] code, [3:1] address, [0] direction
  function automatic logic ctrl_match(input logic [7:0] b,
                                      input logic [3:0] code,
                                      input logic [2:0] strap);
    return (b[7:4] == code) && (b[3:1] == strap);
  endfunction

  function automatic twi_op_e decode_op(input logic [OP_W-1:0] f);
    case (f)
      3'b000:  return OP_DUTY;
      3'b001:  return OP_FULL;
      3'b110:  return OP_SHUT;
      3'b100:  return OP_RECALL;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic shut,
                                             input logic [DUTY_W-1:0] duty);
    return {shut, 2'b00, duty};
  endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       stable_cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean      <= 1'b1;
      stable_cnt <= '0;
    end else if (synced == clean) begin
      stable_cnt <= '0;
    end else if (stable_cnt == CNT_W'(FILT_LEN - 1)) begin
      clean      <= synced;
      stable_cnt <= '0;
    end else begin
      stable_cnt <= stable_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/twi_cmd_fsm.sv
module twi_cmd_fsm
  import twi_cmd_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_f,
  input  logic [2:0]        addr_strap,
  input  logic [DUTY_W-1:0] cur_duty,
  input  logic              cur_shutdown,
  output logic              sda_pull,
  output logic              duty_we,
  output logic [DUTY_W-1:0] duty_val,
  output logic              fullon_stb,
  output logic              shutdown_stb,
  output logic              recall_stb,
  output twi_state_e        state
);
  logic [7:0] rx_sh, tx_sh, status_b;
  logic [3:0] bit_cnt;
  logic       rd_dir, mst_ack;
  twi_op_e    op;

  assign status_b = pack_status(cur_shutdown, cur_duty);
  assign op       = decode_op(rx_sh[7:5]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  sda_pull <= 1'b0;
      rx_sh <= '0;       tx_sh <= '0;      bit_cnt <= '0;
      rd_dir <= 1'b0;    mst_ack <= 1'b0;
      duty_we <= 1'b0;   duty_val <= '0;
      fullon_stb <= 1'b0; shutdown_stb <= 1'b0; recall_stb <= 1'b0;
    end else begin
      duty_we <= 1'b0; fullon_stb <= 1'b0;
      shutdown_stb <= 1'b0; recall_stb <= 1'b0;
      if (start_evt) begin
        state <= ST_ADDR; bit_cnt <= '0; sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state <= ST_IDLE; sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              rx_sh   <= {rx_sh[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (ctrl_match(rx_sh, DEV_CODE, addr_strap)) begin
                  sda_pull <= 1'b1; rd_dir <= rx_sh[0]; state <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_pull <= 1'b1; state <= ST_DACK;
                case (op)
                  OP_DUTY:   begin duty_we <= 1'b1; duty_val <= rx_sh[DUTY_W-1:0]; end
                  OP_FULL:   fullon_stb   <= 1'b1;
                  OP_SHUT:   shutdown_stb <= 1'b1;
                  OP_RECALL: recall_stb   <= 1'b1;
                  default:   ;
                endcase
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_dir) begin
              tx_sh <= status_b; sda_pull <= ~status_b[7]; state <= ST_TX;
            end else begin
              sda_pull <= 1'b0; state <= ST_RX;
            end
          end
          ST_DACK: if (scl_fall) begin
            sda_pull <= 1'b0; bit_cnt <= '0; state <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 4'd7) begin
              sda_pull <= 1'b0; state <= ST_MACK;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0}; sda_pull <= ~tx_sh[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) mst_ack <= ~sda_f;
            else if (scl_fall) begin
              bit_cnt <= '0;
              if (mst_ack) begin
                tx_sh <= status_b; sda_pull <= ~status_b[7]; state <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
  import twi_cmd_pkg::*;
#(
  parameter int         FILT_LEN = 4,
  parameter logic [3:0] DEV_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        addr_strap,
  input  logic [DUTY_W-1:0] cur_duty,
  input  logic              cur_shutdown,
  output logic              sda_pull,
  output logic              duty_we,
  output logic [DUTY_W-1:0] duty_val,
  output logic              fullon_stb,
  output logic              shutdown_stb,
  output logic              recall_stb
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic scl_f, sda_f, start_evt, stop_evt, scl_rise, scl_fall;
  twi_state_e fsm_state;

  assign raw_lines = {sda_in, scl_in};
  assign scl_f     = clean_lines[0];
  assign sda_f     = clean_lines[1];

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    twi_line_filter #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .clean(clean_lines[g])
    );
  end

  twi_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  twi_cmd_fsm #(.DEV_CODE(DEV_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_f(sda_f),
    .addr_strap(addr_strap), .cur_duty(cur_duty), .cur_shutdown(cur_shutdown),
    .sda_pull(sda_pull), .duty_we(duty_we), .duty_val(duty_val),
    .fullon_stb(fullon_stb), .shutdown_stb(shutdown_stb),
    .recall_stb(recall_stb), .state(fsm_state)
  );
endmodule

// File: rtl/twi_cmd_checks.sv
module twi_cmd_checks
  import twi_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       scl_fall,
  input logic       sda_pull,
  input logic       duty_we,
  input logic       fullon_stb,
  input logic       shutdown_stb,
  input logic       recall_stb,
  input twi_state_e state
);
  logic any_stb;
  assign any_stb = duty_we | fullon_stb | shutdown_stb | recall_stb;

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({duty_we, fullon_stb, shutdown_stb, recall_stb}));

  assert_strobe_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(scl_fall));

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  assert_sda_low_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_evt || stop_evt)) |-> !scl_f);

  assert_restart_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR));
endmodule

bind twi_cmd_slave twi_cmd_checks u_checks (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_evt(start_evt),
  .stop_evt(stop_evt), .scl_fall(scl_fall), .sda_pull(sda_pull),
  .duty_we(duty_we), .fullon_stb(fullon_stb), .shutdown_stb(shutdown_stb),
  .recall_stb(recall_stb), .state(fsm_state)
);

// File: tb/twi_cmd_slave_test.sv
module twi_cmd_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int FILT       = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, glitch_sda = 0, glitch_scl = 0;
  logic sda_pull, duty_we, fullon_stb, shutdown_stb, recall_stb;
  logic [4:0] duty_val;
  logic [4:0] reg_duty;
  logic reg_shut;
  logic sda_in, scl_in;
  int n_duty = 0, n_full = 0, n_shut = 0, n_rec = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_in = sda_m & ~sda_pull & ~glitch_sda;
  assign scl_in = scl_m | glitch_scl;

  twi_cmd_slave #(.FILT_LEN(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .addr_strap(STRAP), .cur_duty(reg_duty), .cur_shutdown(reg_shut),
    .sda_pull(sda_pull), .duty_we(duty_we), .duty_val(duty_val),
    .fullon_stb(fullon_stb), .shutdown_stb(shutdown_stb), .recall_stb(recall_stb)
  );

  // register block model fed by the strobes
  always @(negedge clk) begin
    if (!rst_n) begin
      reg_duty = 5'd16; reg_shut = 1'b0;
    end else begin
      if (duty_we)      begin reg_duty = duty_val; n_duty++; end
      if (fullon_stb)   n_full++;
      if (shutdown_stb) begin reg_shut = 1'b1; n_shut++; end
      if (recall_stb)   begin reg_shut = 1'b0; n_rec++; end
    end
  end

  function automatic logic [7:0] ctrl_b(input logic [2:0] a, input logic rd);
    return {4'b0101, a, rd};
  endfunction

  // 0 none, 1 duty, 2 full-on, 3 shutdown, 4 recall
  function automatic int exp_kind(input logic [7:0] b);
    if (b[7:5] == 3'b000) return 1;
    if (b[7:5] == 3'b001) return 2;
    if (b[7:5] == 3'b110) return 3;
    if (b[7:5] == 3'b100) return 4;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1; wq(); scl_m = 1; wq(); wq(); sda_m = 0; wq(); wq(); scl_m = 0;
  endtask

  task automatic m_stop();
    wq(); sda_m = 0; wq(); scl_m = 1; wq(); wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic m_bit(input logic b, input bit glitch);
    if (glitch) begin
      glitch_scl = 1; repeat (FILT-1) @(negedge clk); glitch_scl = 0;
      repeat (Q-FILT+1) @(negedge clk);
    end else wq();
    sda_m = b; wq(); scl_m = 1; wq();
    if (glitch) begin
      glitch_sda = 1; repeat (FILT-1) @(negedge clk); glitch_sda = 0;
      repeat (Q-FILT+1) @(negedge clk);
    end else wq();
    scl_m = 0;
  endtask

  task automatic m_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) m_bit(b[i], 1'b0);
  endtask

  task automatic m_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i], glitch && i == 3);
    wq(); sda_m = 1; wq(); scl_m = 1; wq();
    ack = (sda_in == 1'b0);
    wq(); scl_m = 0;
  endtask

  task automatic m_read(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(); sda_m = 1; wq(); scl_m = 1; wq(); b[i] = sda_in; wq(); scl_m = 0;
    end
    wq(); sda_m = ~give_ack; wq(); scl_m = 1; wq(); wq(); scl_m = 0;
  endtask

  // sends one data byte in a write and checks ack plus strobe outcome
  task automatic write_one(input logic [7:0] b, input bit glitch, input string req);
    int d0, f0, s0, r0, k;
    logic ack;
    d0 = n_duty; f0 = n_full; s0 = n_shut; r0 = n_rec;
    k = exp_kind(b);
    m_byte(b, glitch, ack);
    check(ack === 1'b1, {req, " R4 data ack"}, ack, 1);
    check((n_duty - d0) == (k == 1 ? 1 : 0), {req, " R5 duty strobe"}, n_duty - d0, k == 1);
    check((n_full - f0) == (k == 2 ? 1 : 0), {req, " R5 full-on strobe"}, n_full - f0, k == 2);
    check((n_shut - s0) == (k == 3 ? 1 : 0), {req, " R5 shutdown strobe"}, n_shut - s0, k == 3);
    check((n_rec - r0) == (k == 4 ? 1 : 0), {req, " R5 recall strobe"}, n_rec - r0, k == 4);
    if (k == 1) check(reg_duty == b[4:0], {req, " R5 duty value"}, reg_duty, b[4:0]);
  endtask

  task automatic open_write(input string req);
    logic ack;
    m_start(); m_byte(ctrl_b(STRAP, 1'b0), 1'b0, ack);
    check(ack === 1'b1, {req, " R2 control ack"}, ack, 1);
  endtask

  task automatic read_check(input int n, input string req);
    logic ack;
    logic [7:0] b;
    m_start(); m_byte(ctrl_b(STRAP, 1'b1), 1'b0, ack);
    check(ack === 1'b1, {req, " R2 read control ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      m_read(i != n - 1, b);
      check(b == {reg_shut, 2'b00, reg_duty}, {req, " R7 R8 status byte"},
            b, {reg_shut, 2'b00, reg_duty});
    end
    repeat (2*Q) @(negedge clk);
    check(sda_pull == 1'b0, {req, " R8 released after nack"}, sda_pull, 0);
    m_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    int tot;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R1 reset sda_pull", sda_pull, 0);
    check({duty_we, fullon_stb, shutdown_stb, recall_stb} == 4'b0, "R1 reset strobes",
          {duty_we, fullon_stb, shutdown_stb, recall_stb}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);

    // basic write of a duty value
    open_write("T1");
    write_one(8'h0A, 1'b0, "T1");
    m_stop();
    check(sda_pull == 1'b0, "R1 idle after stop", sda_pull, 0);

    // wrong device code, then wrong strap
    tot = n_duty + n_full + n_shut + n_rec;
    m_start(); m_byte({4'b0110, STRAP, 1'b0}, 1'b0, ack);
    check(ack === 1'b0, "R3 wrong code nack", ack, 0);
    m_byte(8'h05, 1'b0, ack);
    check(ack === 1'b0, "R3 following byte ignored", ack, 0);
    m_stop();
    m_start(); m_byte(ctrl_b(STRAP ^ 3'b010, 1'b0), 1'b0, ack);
    check(ack === 1'b0, "R2 R3 wrong strap nack", ack, 0);
    m_byte(8'h07, 1'b0, ack);
    m_stop();
    check(n_duty + n_full + n_shut + n_rec == tot, "R3 no strobes after refusal",
          n_duty + n_full + n_shut + n_rec, tot);

    // multi-byte write with every operation field, including unused codes
    open_write("T4");
    write_one(8'h20, 1'b0, "R6 T4");
    write_one(8'hC0, 1'b0, "R6 T4");
    write_one(8'h13, 1'b0, "R6 T4");
    write_one(8'h80, 1'b0, "R6 T4");
    write_one(8'h4F, 1'b0, "R6 T4 unused 010");
    write_one(8'hE1, 1'b0, "R6 T4 unused 111");
    write_one(8'hA2, 1'b0, "R6 T4 unused 101");
    m_stop();

    // read back with shutdown set: one byte, then three bytes
    open_write("T5"); write_one(8'hC7, 1'b0, "T5"); m_stop();
    read_check(1, "T5");
    read_check(3, "T5");

    // repeated start mid-byte
    tot = n_duty + n_full + n_shut + n_rec;
    open_write("T6");
    m_bits(8'h1F, 5);
    m_start(); m_byte(ctrl_b(STRAP, 1'b0), 1'b0, ack);
    check(ack === 1'b1, "R9 ack after repeated start", ack, 1);
    check(n_duty + n_full + n_shut + n_rec == tot, "R9 aborted byte no strobe",
          n_duty + n_full + n_shut + n_rec, tot);
    write_one(8'h03, 1'b0, "R9 T6");
    m_stop();

    // stop mid-byte
    tot = n_duty + n_full + n_shut + n_rec;
    open_write("T7");
    m_bits(8'h0E, 4);
    m_stop();
    check(n_duty + n_full + n_shut + n_rec == tot, "R10 stop mid-byte no strobe",
          n_duty + n_full + n_shut + n_rec, tot);
    check(reg_duty == 5'd3, "R10 duty unchanged", reg_duty, 3);

    // glitches on both lines: idle and mid-byte
    glitch_sda = 1; repeat (FILT-1) @(negedge clk); glitch_sda = 0;
    repeat (2*Q) @(negedge clk);
    open_write("R11 T8");
    write_one(8'h0B, 1'b1, "R11 T8");
    m_stop();
    check(reg_duty == 5'd11, "R11 duty after glitches", reg_duty, 11);

    // random writes with periodic read-back
    for (int it = 0; it < 25; it++) begin
      int nb;
      nb = 1 + ($urandom % 3);
      open_write("RND");
      for (int j = 0; j < nb; j++) write_one(8'($urandom), 1'b0, "R6 RND");
      m_stop();
      if (($urandom % 4) == 0) read_check(2, "RND");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule